// File: doc/BRIEF.md
# UART Interrupt Aggregator

This block gathers the thirteen interrupt sources of a UART into one level interrupt for the processor. Each source arrives as a one-cycle pulse from the transmit path, the receive path or the modem-line logic. The pulse sets a sticky status bit. An enable mask decides which of the latched bits may raise the interrupt line.

Software reaches the block through a 32-bit register port. The mask is never written as a whole value. One register turns mask bits on, another turns them off, and a read-only register shows the mask that results. Status bits are cleared by writing ones to the status register. The circuits that generate the events sit outside this block.

Top module: `uart_irq_agg`

## Requirements
- R1: After reset the mask, the status and the `irq` output are all zero.
- R2: A write to offset 0x08 sets every mask bit that has a 1 in the write data. Mask bits written with 0 keep their value.
- R3: A write to offset 0x0C clears every mask bit that has a 1 in the write data. Mask bits written with 0 keep their value. If a set and a clear of the same mask bit meet in one cycle, the clear wins.
- R4: A read of offset 0x10 returns the mask, and a read of offset 0x14 returns the status, both in bits 12:0. Bits 31:13 read as zero, and every other offset reads as zero. A write to 0x10 leaves the mask unchanged.
- R5: An event pulse sets its status bit on the next clock edge, whether the source is enabled or not.
- R6: Status bits are sticky. A bit is cleared only by writing 1 at its position to offset 0x14. Positions written with 0 keep their value.
- R7: If a pulse and a clear of the same status bit happen in one cycle, the bit ends set.
- R8: `irq` is a register. It holds the OR of (status AND mask) as it stood one clock earlier.
- R9: Event input `evt_pulse[i]` drives status bit i and is gated by mask bit i. The sources by bit are: 0 receive threshold reached, 1 receive queue empty, 2 receive queue full, 3 transmit queue empty, 4 transmit queue full, 5 receive overflow, 6 framing error, 7 parity error, 8 receive timeout, 9 modem line change, 10 transmit threshold reached, 11 transmit nearly full, 12 transmit overflow.
- R10: Writing 0x1FFF to offset 0x0C or 0x14 acts on all thirteen sources at once. Write-data bits 31:13 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| evt_pulse | input | 13 | One-cycle event pulses, bit i is source i |
| irq | output | 1 | Level interrupt request |

## Verification
A register write or an event pulse updates the mask or the status at the next clock edge. A read at the matching offset shows the new value in the same cycle, because read data is combinational. `irq` follows one edge later, since it is registered from the updated status and mask. The bench model applies the same update at every rising edge, with the interrupt taken from the values before that edge. It samples `irq` and the read data at the falling edge that follows, so each result is checked in the cycle it is due.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  localparam int NSRC = 13;
  localparam int OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_ENA  = 8'h08;
  localparam logic [OFS_W-1:0] OFS_DIS  = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_MASK = 8'h10;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'h14;

  typedef logic [NSRC-1:0] src_vec_t;

  typedef enum int {
    SRC_RX_THR   = 0,
    SRC_RX_EMPTY = 1,
    SRC_RX_FULL  = 2,
    SRC_TX_EMPTY = 3,
    SRC_TX_FULL  = 4,
    SRC_RX_OVF   = 5,
    SRC_FRAME    = 6,
    SRC_PARITY   = 7,
    SRC_RX_TMO   = 8,
    SRC_MODEM    = 9,
    SRC_TX_THR   = 10,
    SRC_TX_NFULL = 11,
    SRC_TX_OVF   = 12
  } src_id_e;

  // set bits, then let clear bits override them
  function automatic src_vec_t mask_update(src_vec_t cur, src_vec_t on, src_vec_t off);
    return (cur | on) & ~off;
  endfunction

  // clear first, then let new events override the clear
  function automatic src_vec_t stat_update(src_vec_t cur, src_vec_t w1c, src_vec_t evt);
    return (cur & ~w1c) | evt;
  endfunction

  function automatic logic any_pending(src_vec_t stat, src_vec_t mask);
    return |(stat & mask);
  endfunction
endpackage

// File: rtl/uart_irq_mask_unit.sv
`timescale 1ns/1ps
module uart_irq_mask_unit
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_bits,
  input  src_vec_t clr_bits,
  output src_vec_t mask_q
);
  src_vec_t mask_d;

  always_comb mask_d = mask_update(mask_q, set_bits, clr_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits & ~clr_bits) != '0 |=>
      (mask_q & $past(set_bits & ~clr_bits)) == $past(set_bits & ~clr_bits));

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits == '0 && clr_bits == '0) |=> $stable(mask_q));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_bits != '0 |=> (mask_q & $past(clr_bits)) == '0);

  p_dis_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits & clr_bits) != '0 |=> (mask_q & $past(set_bits & clr_bits)) == '0);
endmodule

// File: rtl/uart_irq_status_unit.sv
`timescale 1ns/1ps
module uart_irq_status_unit
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t evt,
  input  src_vec_t w1c_bits,
  output src_vec_t stat_q
);
  src_vec_t stat_d;

  always_comb stat_d = stat_update(stat_q, w1c_bits, evt);

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  p_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt != '0 |=> (stat_q & $past(evt)) == $past(evt));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    w1c_bits == '0 |=> (stat_q & $past(stat_q)) == $past(stat_q));

  p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & w1c_bits) != '0 |=> (stat_q & $past(evt & w1c_bits)) == $past(evt & w1c_bits));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_bits & ~evt) != '0 |=> (stat_q & $past(w1c_bits & ~evt)) == '0);
endmodule

// File: rtl/uart_irq_line.sv
`timescale 1ns/1ps
module uart_irq_line
  import uart_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t stat,
  input  src_vec_t mask,
  output logic     irq_q
);
  logic pend;

  always_comb pend = any_pending(stat, mask);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend;
  end

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & mask) != '0 |=> irq_q);

  p_irq_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & mask) == '0 |=> !irq_q);
endmodule

// File: rtl/uart_irq_agg.sv
`timescale 1ns/1ps
module uart_irq_agg
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   evt_pulse,
  output logic              irq
);
  localparam int PAD_W = DATA_W - NSRC;

  src_vec_t wr_src;
  src_vec_t ena_bits;
  src_vec_t dis_bits;
  src_vec_t w1c_bits;
  src_vec_t mask_q;
  src_vec_t stat_q;
  logic     wr_mask_ro;
  logic     unused_hi;

  assign wr_src     = bus_wdata[NSRC-1:0];
  assign unused_hi  = ^bus_wdata[DATA_W-1:NSRC];
  assign ena_bits   = (bus_wr && bus_addr == OFS_ENA)  ? wr_src : '0;
  assign dis_bits   = (bus_wr && bus_addr == OFS_DIS)  ? wr_src : '0;
  assign w1c_bits   = (bus_wr && bus_addr == OFS_STAT) ? wr_src : '0;
  assign wr_mask_ro = bus_wr && bus_addr == OFS_MASK;

  uart_irq_mask_unit u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (ena_bits),
    .clr_bits (dis_bits),
    .mask_q   (mask_q)
  );

  uart_irq_status_unit u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .w1c_bits (w1c_bits),
    .stat_q   (stat_q)
  );

  uart_irq_line u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (stat_q),
    .mask  (mask_q),
    .irq_q (irq)
  );

  always_comb begin
    case (bus_addr)
      OFS_MASK: bus_rdata = {{PAD_W{1'b0}}, mask_q};
      OFS_STAT: bus_rdata = {{PAD_W{1'b0}}, stat_q};
      default:  bus_rdata = '0;
    endcase
  end

  p_mask_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_ro |=> $stable(mask_q));

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '0 && stat_q == '0 && !irq));
endmodule

// File: tb/tb_uart_irq_agg.sv
`timescale 1ns/1ps
module tb_uart_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [12:0] evt_pulse = 13'h0;
  logic        irq;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  int m_mask = 0;
  int m_stat = 0;
  int m_irq = 0;

  always #2.5 clk = ~clk;

  uart_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare irq at next negedge
  task automatic tick(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [12:0] ev, input string req);
    int nirq;
    bus_wr = wr; bus_addr = a; bus_wdata = d; evt_pulse = ev;
    @(posedge clk);
    if (rst_n) begin
      nirq = ((m_stat & m_mask) != 0) ? 1 : 0;
      if (wr && a == 8'h08) m_mask = m_mask | int'(d[12:0]);
      if (wr && a == 8'h0C) m_mask = m_mask & ~int'(d[12:0]);
      if (wr && a == 8'h14) m_stat = m_stat & ~int'(d[12:0]);
      m_stat = (m_stat | int'(ev)) & 32'h1FFF;
      m_mask = m_mask & 32'h1FFF;
      m_irq = nirq;
    end
    @(negedge clk);
    chk(req, "irq", int'(irq), m_irq);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    int exp;
    bus_wr = 1'b0; bus_addr = a; evt_pulse = '0;
    #1;
    exp = (a == 8'h10) ? m_mask : (a == 8'h14) ? m_stat : 0;
    chk(req, "rdata", int'(bus_rdata), exp);
    tick(0, a, 0, 0, req);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int k = 0; k < 4; k++) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h10, "R1");
    rd(8'h14, "R1");
    // R2 enable with zeros leaves mask alone
    tick(1, 8'h08, 32'h0, 0, "R2");
    rd(8'h10, "R2");
    // R5 all events with mask clear: status set, irq stays low
    tick(0, 8'h00, 0, 13'h1FFF, "R5");
    rd(8'h14, "R5");
    tick(0, 8'h00, 0, 0, "R5");
    // R10 clear all status at once
    tick(1, 8'h14, 32'h0000_1FFF, 0, "R10");
    rd(8'h14, "R10");
    // R9 each source lands on its own bit
    for (int i = 0; i < 13; i++) begin
      tick(0, 8'h00, 0, 13'(1 << i), "R9");
      rd(8'h14, "R9");
      tick(1, 8'h14, 32'(1 << i), 0, "R6");
      rd(8'h14, "R6");
    end
    // R8 transmit-empty pending then enabled: irq one cycle after the mask
    tick(0, 8'h00, 0, 13'h0008, "R8");
    tick(1, 8'h08, 32'h0000_0008, 0, "R2");
    rd(8'h10, "R2");
    tick(0, 8'h00, 0, 0, "R8");
    // R6 zero write and idle cycles keep status
    tick(1, 8'h14, 32'h0, 0, "R6");
    for (int k = 0; k < 5; k++) tick(0, 8'h00, 0, 0, "R6");
    rd(8'h14, "R6");
    // R4 read-only mask, unmapped offsets read zero
    tick(1, 8'h10, 32'h0000_1FFF, 0, "R4");
    rd(8'h10, "R4");
    rd(8'h00, "R4");
    rd(8'h2C, "R4");
    rd(8'h08, "R4");
    // R10 high write bits ignored
    tick(1, 8'h08, 32'hFFFF_E000, 0, "R10");
    rd(8'h10, "R10");
    tick(1, 8'h08, 32'h0000_0A0A, 0, "R2");
    rd(8'h10, "R2");
    // R3 disable one bit, irq drops a cycle later
    tick(1, 8'h0C, 32'h0000_0008, 0, "R3");
    rd(8'h10, "R3");
    tick(0, 8'h00, 0, 0, "R8");
    tick(1, 8'h0C, 32'h0, 0, "R3");
    rd(8'h10, "R3");
    // R8 masked source stays quiet, enabled one fires
    tick(0, 8'h00, 0, 13'h0004, "R8");
    tick(0, 8'h00, 0, 0, "R8");
    tick(0, 8'h00, 0, 13'h0200, "R8");
    tick(0, 8'h00, 0, 0, "R8");
    // R7 event and clear together keep the bit
    tick(1, 8'h14, 32'h0000_1FFF, 13'h0020, "R7");
    rd(8'h14, "R7");
    tick(1, 8'h14, 32'h0000_0020, 0, "R6");
    rd(8'h14, "R6");
    // R10 disable everything
    tick(1, 8'h08, 32'h0000_1FFF, 0, "R10");
    rd(8'h10, "R10");
    tick(1, 8'h0C, 32'hFFFF_FFFF, 0, "R10");
    rd(8'h10, "R10");
    tick(0, 8'h00, 0, 13'h1555, "R5");
    tick(0, 8'h00, 0, 0, "R5");
    rd(8'h14, "R5");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule